// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block maps a 16-bit virtual address from a CPU with three privilege levels (kernel, supervisor, user) onto a 22-bit physical address. The top three bits of the virtual address pick one of eight segments. Each privilege level has its own eight segments for instruction space and its own eight for data space. A segment is described by a base word and a control word. The control word gives the segment length in 64-byte blocks, whether the segment grows upward or downward, and its access rights.

The translation is purely combinational and is computed from the current mode, an instruction/data flag and a read/write flag. The same cycle yields the physical address and an abort flag. The abort flag rises on an unknown mode, an access to a non-resident segment, a write into a read-only segment, or an offset outside the segment's length.

A register-bus slave port sets up the tables. Writes land on the clock edge and reads return data combinationally. Data space is used only for data accesses of modes whose data-space enable bit is set. Every other access, including operand words fetched inline with an instruction (which the CPU flags as instruction fetches), goes through instruction space.

Top module: `seg_xlate`

## Requirements
- R1: After reset every control word, base word and the data-space enable register read as zero, and every translation aborts because all segments are non-resident.
- R2: The physical address is (base word << 6) + virtual bits [12:0], taken modulo 2^22. The segment is virtual bits [15:13].
- R3: In an upward segment (control bit 3 = 0), a block number (virtual bits [12:6]) greater than the length field (control bits [14:8]) aborts. Blocks up to and including the length field pass.
- R4: In a downward segment (control bit 3 = 1), a block number less than the length field aborts. Blocks at or above it pass.
- R5: The access field is control bits [2:1]. 01 is read-only, and a write to it aborts. 11 is read/write. 00 and 10 are non-resident, and any access to them aborts.
- R6: The mode input selects one of three independent table sets: 00 kernel, 01 supervisor, 11 user.
- R7: The data-space enable register at octal 777516 holds bit 2 for kernel, bit 1 for supervisor and bit 0 for user. A data access (isInstr = 0) uses the data-space tables only when its mode's bit is 1. Otherwise it uses the instruction-space tables.
- R8: An access with isInstr = 1 always uses instruction space, even when data space is enabled. Inline operand fetches are signalled this way.
- R9: Register groups start at octal 772300 (kernel), 772200 (supervisor) and 777600 (user). Within a group sit 8 words each of instruction control, data control, instruction base and data base, in that order, indexed by segment. Control words keep only bits [14:8], 3 and [2:1]. Base words keep all 16 bits.
- R10: Mode 10 aborts every translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| va | input | 16 | Virtual address |
| mode | input | 2 | Privilege mode: 00 kernel, 01 supervisor, 11 user |
| isInstr | input | 1 | 1 for instruction-stream fetches, including inline operands |
| isWrite | input | 1 | 1 for a write access |
| paddr | output | 22 | Physical address |
| abort | output | 1 | Translation fault |
| busAddr | input | 18 | Register bus byte address |
| busWe | input | 1 | Register bus write strobe |
| busWdata | input | 16 | Register bus write data |
| busRdata | output | 16 | Register bus read data (combinational) |

## Verification
The bench builds the block with its default parameters: eight segments per table, a 16-bit virtual address and a 22-bit physical address. With these values the full register map is reachable through the bus, including every group base and the data-space enable word. The length field spans the whole 0 to 127 block range, so both ends of upward and downward segments can be checked. The 22-bit width also lets a large base plus offset reach the physical wrap-around point.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int NUM_MODES = 3;
  localparam int NUM_SPACES = 2;
  localparam int NUM_SEG = 8;
  localparam int SEG_W = $clog2(NUM_SEG);
  localparam int NUM_ENT = NUM_MODES * NUM_SPACES * NUM_SEG;
  localparam int IDX_W = $clog2(NUM_ENT);
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] DESC_MASK = 16'h7F0E;

  typedef struct packed {
    logic wrDesc;
    logic wrBase;
    logic wrDsp;
    logic selDesc;
    logic selBase;
    logic selDsp;
    logic [IDX_W-1:0] busIdx;
    logic [IDX_W-1:0] xlIdx;
  } strobe_t;
endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int VA_W = 16,
  parameter int BUS_AW = 18,
  parameter int BLK_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        mode,
  input  logic              isInstr,
  input  logic              isWrite,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWe,
  input  logic [WORD_W-1:0] xlDesc,
  input  logic [NUM_MODES-1:0] dspEn,
  output strobe_t           stb,
  output logic              abort
);
  localparam int OFF_W = VA_W - SEG_W;
  localparam int BLK_W = OFF_W - BLK_SHIFT;
  localparam logic [BUS_AW-1:0] SUP_BASE = 18'o772200;
  localparam logic [BUS_AW-1:0] KER_BASE = 18'o772300;
  localparam logic [BUS_AW-1:0] USR_BASE = 18'o777600;
  localparam logic [BUS_AW-1:0] DSP_ADDR = 18'o777516;

  logic [1:0] modeIdx, busMode;
  logic badMode, useD, grpHit;
  logic [4:0] wordIdx;
  logic [BLK_W-1:0] blk, lenField;
  logic isDown, resident, writable, lenBad;

  always_comb begin
    badMode = 1'b0;
    case (mode)
      2'b00: modeIdx = 2'd0;
      2'b01: modeIdx = 2'd1;
      2'b11: modeIdx = 2'd2;
      default: begin modeIdx = 2'd0; badMode = 1'b1; end
    endcase
    useD = !isInstr && dspEn[2'd2 - modeIdx];
  end

  always_comb begin
    grpHit = 1'b1;
    busMode = 2'd0;
    if (busAddr[BUS_AW-1:6] == KER_BASE[BUS_AW-1:6]) busMode = 2'd0;
    else if (busAddr[BUS_AW-1:6] == SUP_BASE[BUS_AW-1:6]) busMode = 2'd1;
    else if (busAddr[BUS_AW-1:6] == USR_BASE[BUS_AW-1:6]) busMode = 2'd2;
    else grpHit = 1'b0;
    wordIdx = busAddr[5:1];
    stb.selDesc = grpHit && !wordIdx[4];
    stb.selBase = grpHit && wordIdx[4];
    stb.selDsp = busAddr[BUS_AW-1:1] == DSP_ADDR[BUS_AW-1:1];
    stb.wrDesc = busWe && stb.selDesc;
    stb.wrBase = busWe && stb.selBase;
    stb.wrDsp = busWe && stb.selDsp;
    stb.busIdx = {busMode, wordIdx[3], wordIdx[2:0]};
    stb.xlIdx = {modeIdx, useD, va[VA_W-1 -: SEG_W]};
  end

  assign blk = va[OFF_W-1:BLK_SHIFT];
  assign lenField = xlDesc[14:8];
  assign isDown = xlDesc[3];
  assign resident = xlDesc[1];
  assign writable = xlDesc[2];
  assign lenBad = isDown ? (blk < lenField) : (blk > lenField);
  assign abort = badMode | !resident | (isWrite & !writable) | lenBad;

  // R3: upward segment overrun must fault
  a_r3_up_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (!xlDesc[3] && (va[12:6] > xlDesc[14:8])) |-> abort);
  // R4: downward segment underrun must fault
  a_r4_down_underrun: assert property (@(posedge clk) disable iff (!rstN)
    (xlDesc[3] && (va[12:6] < xlDesc[14:8])) |-> abort);
  // R5: non-resident and write-to-read-only fault
  a_r5_access_fault: assert property (@(posedge clk) disable iff (!rstN)
    ((xlDesc[2:1] == 2'b00) || (xlDesc[2:1] == 2'b10) ||
     (isWrite && xlDesc[2:1] == 2'b01)) |-> abort);
  // R8: instruction-stream fetches never select data space
  a_r8_instr_space: assert property (@(posedge clk) disable iff (!rstN)
    isInstr |-> !stb.xlIdx[SEG_W]);
  // R10: unknown mode faults
  a_r10_bad_mode: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b10) |-> abort);
endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int VA_W = 16,
  parameter int PA_W = 22,
  parameter int BLK_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [VA_W-1:0]   va,
  output logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] xlDesc,
  output logic [NUM_MODES-1:0] dspEn,
  output logic [PA_W-1:0]   paddr
);
  localparam int OFF_W = VA_W - SEG_W;

  logic [WORD_W-1:0] descMem [NUM_ENT];
  logic [WORD_W-1:0] baseMem [NUM_ENT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        descMem[i] <= '0;
        baseMem[i] <= '0;
      end
      dspEn <= '0;
    end else begin
      if (stb.wrDesc) descMem[stb.busIdx] <= busWdata & DESC_MASK;
      if (stb.wrBase) baseMem[stb.busIdx] <= busWdata;
      if (stb.wrDsp) dspEn <= busWdata[NUM_MODES-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (stb.selDesc) busRdata = descMem[stb.busIdx];
    else if (stb.selBase) busRdata = baseMem[stb.busIdx];
    else if (stb.selDsp) busRdata = {{(WORD_W-NUM_MODES){1'b0}}, dspEn};
  end

  assign xlDesc = descMem[stb.xlIdx];
  assign paddr = (PA_W'(baseMem[stb.xlIdx]) << BLK_SHIFT) + PA_W'(va[OFF_W-1:0]);

  // R9: a control-word write keeps only the implemented fields
  a_r9_desc_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDesc |=> (descMem[$past(stb.busIdx)] & ~DESC_MASK) == '0);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int VA_W = 16,
  parameter int PA_W = 22,
  parameter int BUS_AW = 18,
  parameter int BLK_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        mode,
  input  logic              isInstr,
  input  logic              isWrite,
  output logic [PA_W-1:0]   paddr,
  output logic              abort,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWe,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata
);
  strobe_t stb;
  logic [WORD_W-1:0] xlDesc;
  logic [NUM_MODES-1:0] dspEn;

  seg_xlate_ctrl #(.VA_W(VA_W), .BUS_AW(BUS_AW), .BLK_SHIFT(BLK_SHIFT)) uCtrl (
    .clk(clk), .rstN(rstN), .va(va), .mode(mode), .isInstr(isInstr),
    .isWrite(isWrite), .busAddr(busAddr), .busWe(busWe), .xlDesc(xlDesc),
    .dspEn(dspEn), .stb(stb), .abort(abort)
  );

  seg_xlate_dp #(.VA_W(VA_W), .PA_W(PA_W), .BLK_SHIFT(BLK_SHIFT)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .va(va),
    .busRdata(busRdata), .xlDesc(xlDesc), .dspEn(dspEn), .paddr(paddr)
  );
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] va = '0;
  logic [1:0] mode = '0;
  logic isInstr = 1'b0, isWrite = 1'b0;
  logic [21:0] paddr;
  logic abort;
  logic [17:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  localparam logic [1:0] MK = 2'b00, MS = 2'b01, MU = 2'b11;

  always #5 clk = ~clk;

  seg_xlate dut (.clk(clk), .rstN(rstN), .va(va), .mode(mode), .isInstr(isInstr),
    .isWrite(isWrite), .paddr(paddr), .abort(abort), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata));

  function automatic logic [17:0] grp(input logic [1:0] m);
    case (m)
      MK: grp = 18'o772300;
      MS: grp = 18'o772200;
      default: grp = 18'o777600;
    endcase
  endfunction
  function automatic logic [17:0] ctlA(input logic [1:0] m, input bit d, input int s);
    ctlA = grp(m) + (d ? 18'd16 : 18'd0) + 18'(s * 2);
  endfunction
  function automatic logic [17:0] baseA(input logic [1:0] m, input bit d, input int s);
    baseA = grp(m) + 18'd32 + (d ? 18'd16 : 18'd0) + 18'(s * 2);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [17:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRd(input logic [17:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic xl(input logic [1:0] m, input logic [15:0] v, input bit ins, input bit wr);
    @(negedge clk);
    mode = m; va = v; isInstr = ins; isWrite = wr;
    #1;
  endtask

  function automatic logic [21:0] pa(input logic [15:0] b, input logic [15:0] v);
    pa = (22'(b) << 6) + 22'(v[12:0]);
  endfunction

  task automatic t_reset;
    logic [15:0] d;
    busRd(ctlA(MK, 0, 0), d); chk("R1 ctl reset", d, 0);
    busRd(baseA(MU, 1, 7), d); chk("R1 base reset", d, 0);
    busRd(18'o777516, d); chk("R1 dspace reset", d, 0);
    xl(MK, 16'h0000, 0, 0); chk("R1 abort after reset", abort, 1);
  endtask

  task automatic t_map;
    logic [15:0] d;
    busWr(ctlA(MS, 1, 5), 16'hFFFF);
    busRd(ctlA(MS, 1, 5), d); chk("R9 ctl mask", d, 16'h7F0E);
    busRd(ctlA(MK, 1, 5), d); chk("R9 other group untouched", d, 0);
    busWr(baseA(MU, 1, 7), 16'hBEEF);
    busRd(baseA(MU, 1, 7), d); chk("R9 base readback", d, 16'hBEEF);
    busWr(18'o777516, 16'hFFFF);
    busRd(18'o777516, d); chk("R9 dspace readback", d, 16'h0007);
    busWr(18'o777516, 16'h0000);
  endtask

  task automatic t_phys;
    busWr(baseA(MK, 0, 1), 16'h1234);
    busWr(ctlA(MK, 0, 1), 16'h7F06);
    xl(MK, 16'h2ABC, 0, 0);
    chk("R2 paddr", paddr, pa(16'h1234, 16'h2ABC)); chk("R2 no abort", abort, 0);
    xl(MK, 16'h2ABC, 0, 1); chk("R5 rw write ok", abort, 0);
    busWr(baseA(MK, 0, 7), 16'hFFFF);
    busWr(ctlA(MK, 0, 7), 16'h7F06);
    xl(MK, 16'hFFFF, 1, 0); chk("R2 wrap 22 bits", paddr, 22'h001FBF);
  endtask

  task automatic t_up;
    busWr(ctlA(MK, 0, 1), 16'h0506);
    xl(MK, 16'h2000, 0, 0); chk("R3 block 0", abort, 0);
    xl(MK, 16'h2140, 0, 0); chk("R3 block = len", abort, 0);
    xl(MK, 16'h217F, 0, 0); chk("R3 last byte of len block", abort, 0);
    xl(MK, 16'h2180, 0, 0); chk("R3 block len+1", abort, 1);
  endtask

  task automatic t_down;
    busWr(ctlA(MK, 0, 1), 16'h7A0E);
    xl(MK, 16'h2000 + 16'(121 * 64), 0, 0); chk("R4 block len-1", abort, 1);
    xl(MK, 16'h2000 + 16'(122 * 64), 0, 0); chk("R4 block = len", abort, 0);
    xl(MK, 16'h3FFF, 0, 0); chk("R4 top block", abort, 0);
    xl(MK, 16'h2000, 0, 0); chk("R4 block 0", abort, 1);
  endtask

  task automatic t_access;
    busWr(ctlA(MK, 0, 1), 16'h7F02);
    xl(MK, 16'h2040, 0, 0); chk("R5 ro read", abort, 0);
    xl(MK, 16'h2040, 0, 1); chk("R5 ro write", abort, 1);
    busWr(ctlA(MK, 0, 1), 16'h7F00);
    xl(MK, 16'h2040, 0, 0); chk("R5 acc 00", abort, 1);
    busWr(ctlA(MK, 0, 1), 16'h7F04);
    xl(MK, 16'h2040, 1, 0); chk("R5 acc 10", abort, 1);
    busWr(ctlA(MK, 0, 1), 16'h7F06);
  endtask

  task automatic t_modes;
    busWr(baseA(MU, 0, 1), 16'h0100);
    busWr(ctlA(MU, 0, 1), 16'h7F06);
    xl(MU, 16'h2010, 0, 0);
    chk("R6 user paddr", paddr, pa(16'h0100, 16'h2010)); chk("R6 user ok", abort, 0);
    xl(MK, 16'h2010, 0, 0); chk("R6 kernel paddr", paddr, pa(16'h1234, 16'h2010));
    xl(MS, 16'h2010, 0, 0); chk("R6 supervisor non-resident", abort, 1);
    xl(2'b10, 16'h2010, 0, 0); chk("R10 bad mode", abort, 1);
  endtask

  task automatic t_dspace;
    busWr(baseA(MK, 1, 1), 16'h0555);
    busWr(ctlA(MK, 1, 1), 16'h7F06);
    xl(MK, 16'h2004, 0, 0); chk("R7 disabled uses I", paddr, pa(16'h1234, 16'h2004));
    busWr(18'o777516, 16'h0004);
    xl(MK, 16'h2004, 0, 0); chk("R7 enabled uses D", paddr, pa(16'h0555, 16'h2004));
    xl(MK, 16'h2004, 1, 0); chk("R8 instr uses I", paddr, pa(16'h1234, 16'h2004));
    xl(MU, 16'h2004, 0, 0); chk("R7 user bit clear uses I", paddr, pa(16'h0100, 16'h2004));
    busWr(18'o777516, 16'h0001);
    xl(MU, 16'h2004, 0, 0); chk("R7 user D non-resident", abort, 1);
    xl(MK, 16'h2004, 0, 0); chk("R7 kernel bit clear", paddr, pa(16'h1234, 16'h2004));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_map();
    t_phys();
    t_up();
    t_down();
    t_access();
    t_modes();
    t_dspace();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChk++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule